// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit sits between a UART's register file, its receive buffer and the outside world, and implements the self-test loopback mode. It holds the control word. While loopback is off, the modem status flags come from the external pins through a synchroniser. Received characters and line-break events from the line are forwarded to the receive buffer. While loopback is on, the unit makes three changes. The software-driven modem outputs appear on the modem status flags in a crossed pairing. The external receive line and its break events are cut off. Every transmitted character, and every assertion of the line-control break bit, is turned into a receive-buffer entry.

The operating mode is a two-state machine. ST_EXTERNAL is entered at reset and through transition T_LEAVE, which is a control write with the loopback bit clear while in ST_LOOPBACK. ST_LOOPBACK is entered through T_ENTER, which is a control write with the loopback bit set while in ST_EXTERNAL. Every other cycle takes T_HOLD. A second two-state machine in the push arbiter tracks a deferred break. PB_NONE moves to PB_HELD through T_DEFER when a break coincides with a data push. PB_HELD returns to PB_NONE through T_FLUSH, in the first cycle with no data push. The receive-push interface is a one-cycle valid strobe with an 11-bit word. Bits 7:0 carry the character and bit 10 marks a break.

Top module: `uart_lbk_top`

## Requirements
- R1: While loopback is on (control bit 7 set), the flag output carries CTS at bit 0 = control bit 11 (RTS), DSR at bit 1 = control bit 10 (DTR), DCD at bit 2 = control bit 12 (Out1) and RI at bit 8 = control bit 13 (Out2), with bits 7:3 zero. The flags follow the control word from the clock edge that writes it.
- R2: While loopback is off, flag bits 0, 1, 2 and 8 equal pins ext_modem[0] (CTS), [1] (DSR), [2] (DCD) and [3] (RI) as they were two clock edges earlier.
- R3: A control write whose data has bit 7 set rewrites the modem interrupt bits to {DSR, DCD, CTS, RI} = {wdata[10], wdata[12], wdata[11], wdata[13]} at bit positions 3..0. This holds even when only the loopback bit changes. All other cycles leave them unchanged.
- R4: While loopback is on, rx_valid and ext_brk produce no receive push.
- R5: While loopback is on, a tx_valid cycle produces a push one cycle later with the character in bits 7:0 and bit 10 clear.
- R6: While loopback is on, a line-control write that changes the break bit from 0 to 1 pushes the word 0x400. A write leaving it at 1, or any break-bit write while loopback is off, pushes nothing.
- R7: While loopback is off, rx_valid pushes the character one cycle later, ext_brk pushes 0x400, and tx_valid pushes nothing.
- R8: After reset the control word reads 0x300, so loopback is off, and the flags, interrupt bits and push strobe are zero.
- R9: A break that arrives together with a data push is pushed as 0x400 in the next cycle that has no data push.
- R10: Inputs presented in the same cycle as a mode-changing control write are handled under the mode in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Break bit of the line-control write data |
| ext_modem | input | 4 | External pins {RI, DCD, DSR, CTS} |
| rx_valid | input | 1 | External received character strobe |
| rx_data | input | 8 | External received character |
| ext_brk | input | 1 | External line-break event strobe |
| tx_valid | input | 1 | Transmitted character strobe |
| tx_data | input | 8 | Transmitted character |
| ctrl_reg | output | 16 | Current control word |
| modem_flags | output | 9 | Modem status flags (bits 0, 1, 2, 8 used) |
| mdm_int | output | 4 | Modem interrupt status {DSR, DCD, CTS, RI} |
| push_valid | output | 1 | Receive-buffer push strobe |
| push_word | output | 11 | Receive-buffer word, bit 10 = break |

## Verification
The bench builds the block with its default parameters: 8-bit characters, the break marker at bit 10 and a two-stage pin synchroniser. With these, every receive-buffer word is fully determined and the two-edge pin delay can be checked exactly. Directed sequences place a break on the same cycle as a data push, a mode change on the same cycle as traffic, and repeated break-bit writes. A long stretch of random traffic then reaches combinations of the deferred break and the mode switch that the directed part does not reach.

// File: rtl/uart_lbk_pkg.sv
package uart_lbk_pkg;
    localparam int CTRL_W   = 16;
    localparam int FLAG_W   = 9;
    localparam int PIN_W    = 4;
    // control word bit positions
    localparam int C_LOOP   = 7;
    localparam int C_DTR    = 10;
    localparam int C_RTS    = 11;
    localparam int C_OUT1   = 12;
    localparam int C_OUT2   = 13;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0300;
    // flag bit positions
    localparam int F_CTS    = 0;
    localparam int F_DSR    = 1;
    localparam int F_DCD    = 2;
    localparam int F_RI     = 8;

    typedef enum logic [0:0] {ST_EXTERNAL, ST_LOOPBACK} lbk_mode_e;
    typedef enum logic [0:0] {PB_NONE, PB_HELD} brk_hold_e;

    // pin order {RI, DCD, DSR, CTS}
    function automatic logic [PIN_W-1:0] looped_pins(input logic [CTRL_W-1:0] c);
        return {c[C_OUT2], c[C_OUT1], c[C_DTR], c[C_RTS]};
    endfunction

    function automatic logic [FLAG_W-1:0] pins_to_flags(input logic [PIN_W-1:0] p);
        logic [FLAG_W-1:0] f;
        f        = '0;
        f[F_CTS] = p[0];
        f[F_DSR] = p[1];
        f[F_DCD] = p[2];
        f[F_RI]  = p[3];
        return f;
    endfunction

    // interrupt order {DSR, DCD, CTS, RI}
    function automatic logic [PIN_W-1:0] pins_to_int(input logic [PIN_W-1:0] p);
        return {p[1], p[2], p[0], p[3]};
    endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_mode_fsm.sv
module mdm_mode_fsm
    import uart_lbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              lcr_wr,
    input  logic              lcr_brk,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              loop_on,
    output logic [PIN_W-1:0]  int_bits,
    output logic              brk_rise
);
    lbk_mode_e state_q, state_d;
    logic      brk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EXTERNAL;
        else        state_q <= state_d;
    end

    // transitions: T_ENTER, T_LEAVE, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EXTERNAL: if (ctrl_wr && ctrl_wdata[C_LOOP])  state_d = ST_LOOPBACK;
            ST_LOOPBACK: if (ctrl_wr && !ctrl_wdata[C_LOOP]) state_d = ST_EXTERNAL;
            default:     state_d = ST_EXTERNAL;
        endcase
    end

    // outputs
    always_comb begin
        loop_on  = (state_q == ST_LOOPBACK);
        brk_rise = lcr_wr && lcr_brk && !brk_q;
    end

    // control word, break bit and modem interrupt status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RESET;
            brk_q    <= 1'b0;
            int_bits <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_wdata;
                if (ctrl_wdata[C_LOOP])
                    int_bits <= pins_to_int(looped_pins(ctrl_wdata));
            end
            if (lcr_wr) brk_q <= lcr_brk;
        end
    end
endmodule

// File: rtl/mdm_push_arb.sv
module mdm_push_arb
    import uart_lbk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_POS = 10,
    localparam int PUSH_W = BRK_POS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_on,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ext_brk,
    input  logic              brk_rise,
    output logic              push_valid,
    output logic [PUSH_W-1:0] push_word
);
    localparam logic [PUSH_W-1:0] BRK_WORD = PUSH_W'(1) << BRK_POS;

    brk_hold_e         hold_q, hold_d;
    logic              data_req, brk_req, brk_any;
    logic [DATA_W-1:0] data_sel;
    logic              pv_d;
    logic [PUSH_W-1:0] pw_d;

    // hold state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= PB_NONE;
        else        hold_q <= hold_d;
    end

    always_comb begin
        data_req = loop_on ? tx_valid : rx_valid;
        data_sel = loop_on ? tx_data  : rx_data;
        brk_req  = loop_on ? brk_rise : ext_brk;
        brk_any  = brk_req || (hold_q == PB_HELD);
    end

    // transitions T_DEFER, T_FLUSH and push selection
    always_comb begin
        hold_d = hold_q;
        pv_d   = 1'b0;
        pw_d   = '0;
        unique case (hold_q)
            PB_NONE: begin
                if (data_req) begin
                    pv_d = 1'b1;
                    pw_d = PUSH_W'(data_sel);
                    if (brk_req) hold_d = PB_HELD;
                end else if (brk_req) begin
                    pv_d = 1'b1;
                    pw_d = BRK_WORD;
                end
            end
            PB_HELD: begin
                if (data_req) begin
                    pv_d = 1'b1;
                    pw_d = PUSH_W'(data_sel);
                end else begin
                    pv_d   = brk_any;
                    pw_d   = BRK_WORD;
                    hold_d = PB_NONE;
                end
            end
            default: hold_d = PB_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_word  <= '0;
        end else begin
            push_valid <= pv_d;
            push_word  <= pw_d;
        end
    end
endmodule

// File: rtl/uart_lbk_top.sv
module uart_lbk_top
    import uart_lbk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BRK_POS     = 10,
    parameter int SYNC_STAGES = 2,
    localparam int PUSH_W     = BRK_POS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              lcr_wr,
    input  logic              lcr_brk,
    input  logic [PIN_W-1:0]  ext_modem,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ext_brk,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [FLAG_W-1:0] modem_flags,
    output logic [PIN_W-1:0]  mdm_int,
    output logic              push_valid,
    output logic [PUSH_W-1:0] push_word
);
    logic             loop_on;
    logic             brk_rise;
    logic [PIN_W-1:0] pins_sync;

    mdm_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ext_modem),
        .q    (pins_sync)
    );

    mdm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_wdata(ctrl_wdata),
        .lcr_wr    (lcr_wr),
        .lcr_brk   (lcr_brk),
        .ctrl_q    (ctrl_reg),
        .loop_on   (loop_on),
        .int_bits  (mdm_int),
        .brk_rise  (brk_rise)
    );

    mdm_push_arb #(.DATA_W(DATA_W), .BRK_POS(BRK_POS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_on   (loop_on),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .ext_brk   (ext_brk),
        .brk_rise  (brk_rise),
        .push_valid(push_valid),
        .push_word (push_word)
    );

    always_comb begin
        modem_flags = pins_to_flags(loop_on ? looped_pins(ctrl_reg) : pins_sync);
    end
endmodule

// File: rtl/uart_lbk_chk.sv
module uart_lbk_chk #(
    parameter int DATA_W  = 8,
    parameter int BRK_POS = 10,
    localparam int PUSH_W = BRK_POS + 1,
    localparam int PAD_W  = PUSH_W - DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [15:0]       ctrl_wdata,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              ext_brk,
    input logic [15:0]       ctrl_reg,
    input logic [8:0]        modem_flags,
    input logic [3:0]        mdm_int,
    input logic              push_valid,
    input logic [PUSH_W-1:0] push_word
);
    AST_LOOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reg[7] |-> modem_flags == {ctrl_reg[13], 5'b0, ctrl_reg[12], ctrl_reg[10], ctrl_reg[11]}); // R1

    AST_INT_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[7]) |=> mdm_int == {$past(ctrl_wdata[10]), $past(ctrl_wdata[12]),
                                                   $past(ctrl_wdata[11]), $past(ctrl_wdata[13])}); // R3

    AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && ctrl_wdata[7]) |=> $stable(mdm_int)); // R3

    AST_LOOP_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[7] && rx_valid && !tx_valid) |=> (!push_valid || push_word[BRK_POS])); // R4

    AST_LOOP_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[7] && tx_valid) |=> (push_valid && push_word == {{PAD_W{1'b0}}, $past(tx_data)})); // R5

    AST_EXT_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_reg[7] && rx_valid) |=> (push_valid && push_word == {{PAD_W{1'b0}}, $past(rx_data)})); // R7

    AST_EXT_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_reg[7] && tx_valid && !rx_valid && !ext_brk) |=> (!push_valid || push_word[BRK_POS])); // R7
endmodule

bind uart_lbk_top uart_lbk_chk #(.DATA_W(DATA_W), .BRK_POS(BRK_POS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .ext_brk    (ext_brk),
    .ctrl_reg   (ctrl_reg),
    .modem_flags(modem_flags),
    .mdm_int    (mdm_int),
    .push_valid (push_valid),
    .push_word  (push_word)
);

// File: tb/tb_uart_lbk_top.sv
`timescale 1ns/1ps
module tb_uart_lbk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        lcr_wr = 1'b0;
    logic        lcr_brk = 1'b0;
    logic [3:0]  ext_modem = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        ext_brk = 1'b0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [15:0] ctrl_reg;
    logic [8:0]  modem_flags;
    logic [3:0]  mdm_int;
    logic        push_valid;
    logic [10:0] push_word;

    always #2.5 clk = ~clk;

    uart_lbk_top dut (.*);

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference model state
    int m_ctrl = 'h300;
    int m_int = 0;
    int m_brk = 0;
    int m_hold = 0;
    int m_s1 = 0;
    int m_s2 = 0;
    int e_pv = 0;
    int e_pw = 0;
    string push_tag = "R8";

    function automatic int loop_flags(int c);
        int f = 0;
        if (c & (1 << 11)) f += 1;
        if (c & (1 << 10)) f += 2;
        if (c & (1 << 12)) f += 4;
        if (c & (1 << 13)) f += 256;
        return f;
    endfunction

    function automatic int pin_flags(int p);
        return (p & 7) + (((p >> 3) & 1) * 256);
    endfunction

    function automatic int loop_int(int c);
        int v = 0;
        if (c & (1 << 13)) v += 1;
        if (c & (1 << 11)) v += 2;
        if (c & (1 << 12)) v += 4;
        if (c & (1 << 10)) v += 8;
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 'h300; m_int = 0; m_brk = 0; m_hold = 0;
            m_s1 = 0; m_s2 = 0; e_pv = 0; e_pw = 0; push_tag = "R8";
        end else begin
            int loop_old, dreq, breq, rise, dval;
            loop_old = (m_ctrl >> 7) & 1;
            m_s2 = m_s1;
            m_s1 = ext_modem;
            rise = lcr_wr && lcr_brk && (m_brk == 0);
            if (lcr_wr) m_brk = lcr_brk;
            dreq = loop_old ? tx_valid : rx_valid;
            dval = loop_old ? tx_data : rx_data;
            breq = loop_old ? rise : ext_brk;
            e_pv = 0; e_pw = 0;
            push_tag = loop_old ? "R4" : "R7";
            if (dreq) begin
                e_pv = 1; e_pw = dval;
                push_tag = loop_old ? "R5" : "R7";
                if (breq) m_hold = 1;
            end else if (breq || m_hold) begin
                e_pv = 1; e_pw = 'h400;
                push_tag = m_hold ? "R9" : (loop_old ? "R6" : "R7");
                m_hold = 0;
            end
            if (ctrl_wr) begin
                if (((ctrl_wdata >> 7) & 1) != loop_old) push_tag = "R10";
                m_ctrl = ctrl_wdata;
                if (ctrl_wdata[7]) m_int = loop_int(ctrl_wdata);
            end
        end
        #1;
        if (!finished) begin
            check("R8", "ctrl_reg", ctrl_reg, m_ctrl);
            if ((m_ctrl >> 7) & 1) check("R1", "modem_flags", modem_flags, loop_flags(m_ctrl));
            else                   check("R2", "modem_flags", modem_flags, pin_flags(m_s2));
            check("R3", "mdm_int", mdm_int, m_int);
            check(push_tag, "push_valid", push_valid, e_pv);
            if (e_pv) check(push_tag, "push_word", push_word, e_pw);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [15:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic wr_lcr(logic b);
        @(negedge clk); lcr_wr = 1; lcr_brk = b;
        @(negedge clk); lcr_wr = 0;
    endtask

    task automatic send_tx(logic [7:0] d);
        @(negedge clk); tx_valid = 1; tx_data = d;
        @(negedge clk); tx_valid = 0;
    endtask

    task automatic send_rx(logic [7:0] d);
        @(negedge clk); rx_valid = 1; rx_data = d;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic pulse_brk();
        @(negedge clk); ext_brk = 1;
        @(negedge clk); ext_brk = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1;                                  // R8 reset state compared
        idle(2);
        ext_modem = 4'b1010; idle(4);               // R2
        ext_modem = 4'b0101; idle(4);               // R2
        send_rx(8'h5A);                             // R7
        pulse_brk();                                // R7
        send_tx(8'h33);                             // R7 no push
        wr_lcr(1); wr_lcr(0);                       // R6 no push while external
        @(negedge clk); rx_valid = 1; rx_data = 8'hA5; ext_brk = 1;   // R9
        @(negedge clk); rx_valid = 0; ext_brk = 0;
        idle(2);
        wr_ctrl(16'h0380);                          // R3 enter with outputs low
        wr_ctrl(16'h3F80);                          // R1 R3
        wr_ctrl(16'h2480);
        wr_ctrl(16'h1880);
        ext_modem = 4'b1111; idle(3);               // R1 pins ignored
        send_rx(8'h77);                             // R4
        pulse_brk();                                // R4
        send_tx(8'hC3);                             // R5
        wr_lcr(1);                                  // R6 push 0x400
        wr_lcr(1);                                  // R6 no push
        wr_lcr(0);
        @(negedge clk); lcr_wr = 1; lcr_brk = 1; tx_valid = 1; tx_data = 8'h0F;  // R9
        @(negedge clk); lcr_wr = 0; tx_valid = 0;
        idle(2);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = 16'h0300; tx_valid = 1; tx_data = 8'h99; // R10
        @(negedge clk); ctrl_wr = 0; tx_valid = 0;
        send_rx(8'h42);                             // R7 after leave
        wr_ctrl(16'h3F00);                          // R3 interrupt held
        idle(3);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = 16'h0B80; rx_valid = 1; rx_data = 8'h11; // R10
        @(negedge clk); ctrl_wr = 0; rx_valid = 0;
        idle(2);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ctrl_wr    = ($urandom % 8) == 0;
            ctrl_wdata = 16'($urandom);
            lcr_wr     = ($urandom % 4) == 0;
            lcr_brk    = 1'($urandom);
            ext_modem  = 4'($urandom);
            rx_valid   = 1'($urandom);
            rx_data    = 8'($urandom);
            ext_brk    = ($urandom % 4) == 0;
            tx_valid   = 1'($urandom);
            tx_data    = 8'($urandom);
        end
        @(negedge clk);
        ctrl_wr = 0; lcr_wr = 0; rx_valid = 0; ext_brk = 0; tx_valid = 0;
        idle(4);
        finish_run();
    end
endmodule